// File: doc/BRIEF.md
# MDIO Management Master with Bus Routing

This block is a memory-mapped master for the two-wire management interface used to reach Ethernet PHY registers. Software programs a parameter word (target PHY, write data, Clause 45 flag, and which of eight internal or eight external management buses to use), an address word, and the MDC rate settings. It then writes a command code to start a frame. The block generates MDC, drives or releases the MDIO data line through an output/enable pair, and shifts in read data. It raises a done flag that software clears by writing a zero command.

Clause 22 frames are sent in a single pass. Clause 45 accesses are sent as an address frame followed by a data frame. The MDC period is set by the rate register that belongs to the selected bus type. That period is captured when a frame starts, so a register write in the middle of a frame does not bend the clock.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the status register reads 0, the parameter register reads 0, MDC is low and MDIO is not driven (`mdio_oe` = 0). While no frame is running, MDC stays low and MDIO stays released.
- R2: The parameter word (offset 0x23C) reads back its bits 25:0. `bus_internal` follows bit 25 and `bus_index` follows bits 24:22. The external-rate register (0x000) reads back divisor bits 15:0 and dividend bits 23:16. `ext_mstr_block` follows bit 28 of the scan-control register (0x008).
- R3: While a frame runs, the MDC period is max(divisor,1) × (dividend+1) core clocks, with a minimum of 2. The rate comes from 0x004 when parameter bit 25 is 1 and from 0x000 otherwise.
- R4: A Clause 22 write frame (parameter bit 21 = 0, command 1) puts the following on MDIO, one bit per MDC period, MSB first, with MDIO driven throughout: 32 ones, start 01, op 01, PHY address (parameter bits 20:16), register (address bits 4:0), turnaround 10, then data (parameter bits 15:0). MDIO changes only while MDC is low.
- R5: A Clause 22 read frame (command 2) sends op 10 and releases MDIO from the turnaround bit (bit 46 of the 64) to the end of the frame. It samples MDIO on the rising MDC edge of bits 48..63, MSB first. The read-data register (0x240) then holds the sample in bits 15:0, and its upper bits read 0.
- R6: With parameter bit 21 = 1, an address frame (start 00, op 00, PHY, device = address bits 20:16, turnaround 10, address bits 15:0) comes first. It is followed by a data frame with start 00 and op 01 for a write or op 11 for a read. The data frame otherwise has the same layout as in R4 and R5, with the device address in the register field.
- R7: Status bit 0 (0x24C) becomes 1 when the last frame ends. At that point MDC is low and MDIO is released. Writing 0 to the command register (0x248) clears the flag. Writing 0 in the middle of a frame stops it at once, with MDC low, MDIO released and the flag at 0.
- R8: A command of 1 or 2 starts a frame only when no frame is running and the done flag is 0. In any other case it does nothing, so the done flag stays 1 and no MDC edge appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; `reg_rdata` is valid on the following cycle |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |
| bus_internal | output | 1 | 1 selects an internal bus, 0 selects an external one |
| bus_index | output | 3 | Index of the selected bus |
| ext_mstr_block | output | 1 | Keeps any external management master off the buses |

## Verification
The bench covers four corner cases:
- An odd MDC period and the minimum period of two clocks, where the rising edge and the end of the bit fall in the same cycle. A design that treated these wrongly would lose the final read bit or stretch the frame.
- Clause 45 reads, which must produce two frames with different start and op codes. A design that skipped the address phase would send one frame too few.
- The turnaround release. Driving bit 46 would collide with the PHY.
- A start command written while done is still 1, and an abort in the middle of a frame. A block that got these wrong would restart the bus or leave MDC toggling.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  parameter int DIV_W = 16;
  parameter int DVD_W = 8;
  parameter int PER_W = DIV_W + DVD_W + 1;

  localparam logic [11:0] OFS_RATE_EXT = 12'h000;
  localparam logic [11:0] OFS_RATE_INT = 12'h004;
  localparam logic [11:0] OFS_SCAN     = 12'h008;
  localparam logic [11:0] OFS_PARAM    = 12'h23C;
  localparam logic [11:0] OFS_RDATA    = 12'h240;
  localparam logic [11:0] OFS_ADDR     = 12'h244;
  localparam logic [11:0] OFS_CMD      = 12'h248;
  localparam logic [11:0] OFS_STAT     = 12'h24C;

  // MDC period in core clocks: divisor (zero counts as one) times dividend+1, at least 2
  function automatic logic [PER_W-1:0] mdc_period(input logic [DIV_W-1:0] dv,
                                                  input logic [DVD_W-1:0] dd);
    logic [PER_W-1:0] d, m, p;
    d = (dv == '0) ? PER_W'(1) : PER_W'(dv);
    m = PER_W'(dd) + PER_W'(1);
    p = d * m;
    return (p < PER_W'(2)) ? PER_W'(2) : p;
  endfunction

  // 32 bits that follow the preamble
  function automatic logic [31:0] frame_word(input logic c45, input logic addr_ph,
                                             input logic rd, input logic [4:0] phy,
                                             input logic [4:0] dev, input logic [15:0] payload);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    if (c45 && addr_ph) op = 2'b00;
    else if (c45)       op = rd ? 2'b11 : 2'b01;
    else                op = rd ? 2'b10 : 2'b01;
    return {st, op, phy, dev, 2'b10, payload};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             mdc,
  output logic             rise_evt,
  output logic             bit_end
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] half;

  assign half = period >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!run)                    cnt <= '0;
    else if (cnt == period - 1'b1)    cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign mdc      = run && (cnt >= half);
  assign rise_evt = run && (cnt == half);
  assign bit_end  = run && (cnt == period - 1'b1);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             is_read,
  input  logic             c45,
  input  logic [4:0]       phy,
  input  logic [20:0]      regword,
  input  logic [15:0]      wdata,
  input  logic [PER_W-1:0] period_in,
  input  logic             rise_evt,
  input  logic             bit_end,
  input  logic             mdio_i,
  output logic [PER_W-1:0] period_q,
  output logic             busy,
  output logic             done,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [15:0]      rd_data
);
  logic        rd_q, c45_q, addr_ph;
  logic [4:0]  phy_q;
  logic [20:0] reg_q;
  logic [15:0] wd_q;
  logic [5:0]  bit_idx;
  logic [31:0] cur_word;
  logic        data_rd, released, last_bit;

  assign cur_word = frame_word(c45_q, addr_ph, rd_q, phy_q,
                               c45_q ? reg_q[20:16] : reg_q[4:0],
                               addr_ph ? reg_q[15:0] : wd_q);
  assign data_rd  = rd_q && !addr_ph;
  assign released = data_rd && (bit_idx >= 6'd46);
  assign last_bit = (bit_idx == 6'd63);
  assign mdio_oe  = busy && !released;
  assign mdio_o   = mdio_oe && (bit_idx[5] ? cur_word[~bit_idx[4:0]] : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rd_q <= 1'b0; c45_q <= 1'b0; addr_ph <= 1'b0;
      phy_q <= '0; reg_q <= '0; wd_q <= '0; bit_idx <= '0; rd_data <= '0;
      period_q <= PER_W'(2);
    end else if (abort) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      busy <= 1'b1; done <= 1'b0; rd_q <= is_read; c45_q <= c45; addr_ph <= c45;
      phy_q <= phy; reg_q <= regword; wd_q <= wdata; bit_idx <= '0; rd_data <= '0;
      period_q <= period_in;
    end else if (busy) begin
      if (rise_evt && data_rd && (bit_idx >= 6'd48))
        rd_data <= {rd_data[14:0], mdio_i};
      if (bit_end) begin
        if (!last_bit) begin
          bit_idx <= bit_idx + 1'b1;
        end else if (addr_ph) begin
          addr_ph <= 1'b0;
          bit_idx <= '0;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              bus_internal,
  output logic [2:0]        bus_index,
  output logic              ext_mstr_block
);
  localparam int RATE_W = DVD_W + DIV_W;

  logic [RATE_W-1:0] rate_ext, rate_int;
  logic              scan_q;
  logic [25:0]       param_q;
  logic [20:0]       addr_q;
  logic [1:0]        cmd_q;
  logic              eng_busy, stat_done;
  logic [15:0]       rd_data;
  logic [PER_W-1:0]  period_sel, period_q;
  logic              rise_evt, bit_end;
  logic              cmd_wr, start_req, abort_req;
  logic [RATE_W-1:0] rate_sel;

  assign cmd_wr    = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
  assign abort_req = cmd_wr && (reg_wdata == 32'd0);
  assign start_req = cmd_wr && (reg_wdata[31:2] == '0) && (reg_wdata[1] ^ reg_wdata[0])
                     && !eng_busy && !stat_done;

  assign rate_sel   = param_q[25] ? rate_int : rate_ext;
  assign period_sel = mdc_period(rate_sel[DIV_W-1:0], rate_sel[RATE_W-1:DIV_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_ext <= '0; rate_int <= '0; scan_q <= 1'b0;
      param_q <= '0; addr_q <= '0; cmd_q <= '0;
    end else if (reg_wr) begin
      unique case (reg_addr)
        ADDR_W'(OFS_RATE_EXT): rate_ext <= reg_wdata[RATE_W-1:0];
        ADDR_W'(OFS_RATE_INT): rate_int <= reg_wdata[RATE_W-1:0];
        ADDR_W'(OFS_SCAN):     scan_q   <= reg_wdata[28];
        ADDR_W'(OFS_PARAM):    param_q  <= reg_wdata[25:0];
        ADDR_W'(OFS_ADDR):     addr_q   <= reg_wdata[20:0];
        ADDR_W'(OFS_CMD):      cmd_q    <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      unique case (reg_addr)
        ADDR_W'(OFS_RATE_EXT): reg_rdata <= 32'(rate_ext);
        ADDR_W'(OFS_RATE_INT): reg_rdata <= 32'(rate_int);
        ADDR_W'(OFS_SCAN):     reg_rdata <= {3'b0, scan_q, 28'b0};
        ADDR_W'(OFS_PARAM):    reg_rdata <= {6'b0, param_q};
        ADDR_W'(OFS_RDATA):    reg_rdata <= {16'b0, rd_data};
        ADDR_W'(OFS_ADDR):     reg_rdata <= {11'b0, addr_q};
        ADDR_W'(OFS_CMD):      reg_rdata <= {30'b0, cmd_q};
        ADDR_W'(OFS_STAT):     reg_rdata <= {31'b0, stat_done};
        default:               reg_rdata <= '0;
      endcase
    end
  end

  assign bus_internal   = param_q[25];
  assign bus_index      = param_q[24:22];
  assign ext_mstr_block = scan_q;

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_req), .abort(abort_req),
    .is_read(reg_wdata[1]), .c45(param_q[21]), .phy(param_q[20:16]),
    .regword(addr_q), .wdata(param_q[15:0]), .period_in(period_sel),
    .rise_evt(rise_evt), .bit_end(bit_end), .mdio_i(mdio_i),
    .period_q(period_q), .busy(eng_busy), .done(stat_done),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  mdio_mdc_gen u_mdc (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .period(period_q),
    .mdc(mdc), .rise_evt(rise_evt), .bit_end(bit_end)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        done,
  input logic        reg_wr,
  input logic [11:0] reg_addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R1
  AST_MDIO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4
  AST_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && busy) |-> !mdc); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R7
  AST_START_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && (reg_addr == 12'h248))); // R8
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(eng_busy), .done(stat_done), .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i = 0;
  logic bus_internal, ext_mstr_block;
  logic [2:0] bus_index;

  always #2 clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .bus_internal(bus_internal),
    .bus_index(bus_index), .ext_mstr_block(ext_mstr_block)
  );

  int checks = 0, fails = 0;
  int cyc = 0, prev_rise = 0, last_period = 0, rises = 0, nbits = 0;
  bit mon_en = 0, finished = 0;
  logic [63:0] exp_q[$];
  logic [63:0] exp_oe_q[$];
  logic [63:0] cap = 0, capoe = 0;
  logic [15:0] resp = 0;
  string cur_tag = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: assembles frames on rising MDC and pops the scoreboard
  always @(posedge mdc) begin
    #1;
    rises++;
    last_period = cyc - prev_rise;
    prev_rise = cyc;
    if (mon_en) begin
      cap   = {cap[62:0], mdio_oe ? mdio_o : 1'b0};
      capoe = {capoe[62:0], mdio_oe};
      nbits++;
      if (nbits == 64) begin
        nbits = 0;
        if (exp_q.size() == 0) chk(0, {cur_tag, " unexpected frame"}, cap, 64'h0);
        else begin
          logic [63:0] e, eo;
          e = exp_q.pop_front();
          eo = exp_oe_q.pop_front();
          chk(cap == e, {cur_tag, " frame bits"}, cap, e);
          chk(capoe == eo, {cur_tag, " drive enable"}, capoe, eo);
        end
      end
    end
  end

  // PHY response: present the next read bit while MDC is low
  always @(negedge mdc) begin
    if (nbits >= 48 && nbits <= 63) mdio_i = resp[63 - nbits];
    else mdio_i = 1'b0;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic push_frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] dev, input logic [15:0] pay, input bit released);
    if (released) begin
      exp_q.push_back({32'hFFFF_FFFF, st, op, phy, dev, 18'b0});
      exp_oe_q.push_back({{46{1'b1}}, 18'b0});
    end else begin
      exp_q.push_back({32'hFFFF_FFFF, st, op, phy, dev, 2'b10, pay});
      exp_oe_q.push_back({64{1'b1}});
    end
  endtask

  task automatic do_xact(input bit c45, input bit rdop, input bit intl, input logic [2:0] idx,
                         input logic [4:0] phy, input logic [20:0] ra, input logic [15:0] wd,
                         input logic [15:0] rsp, input int per, input string tag);
    logic [31:0] v;
    bit got;
    cur_tag = tag;
    resp = rsp;
    nbits = 0;
    mon_en = 1;
    wr(12'h23C, {6'd0, intl, idx, c45, phy, wd});
    wr(12'h244, {11'd0, ra});
    wr(12'h248, 32'd0);
    if (c45) begin
      push_frame(2'b00, 2'b00, phy, ra[20:16], ra[15:0], 0);
      push_frame(2'b00, rdop ? 2'b11 : 2'b01, phy, ra[20:16], wd, rdop);
    end else
      push_frame(2'b01, rdop ? 2'b10 : 2'b01, phy, ra[4:0], wd, rdop);
    wr(12'h248, rdop ? 32'd2 : 32'd1);
    got = 0;
    for (int i = 0; i < 20000 && !got; i++) begin
      rd(12'h24C, v);
      got = v[0];
    end
    chk(got, {tag, " R7 done flag"}, 64'(got), 64'd1);
    for (int i = 0; i < 1000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " all frames seen"}, 64'(exp_q.size()), 64'd0);
    chk(last_period == per, {tag, " R3 MDC period"}, 64'(last_period), 64'(per));
    chk(mdc == 0 && mdio_oe == 0, {tag, " R7 idle lines at done"}, {mdc, mdio_oe}, 64'd0);
    if (rdop) begin
      rd(12'h240, v);
      chk(v == {16'b0, rsp}, {tag, " read data"}, 64'(v), 64'({16'b0, rsp}));
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mdc == 0 && mdio_oe == 0, "R1 lines after reset", {mdc, mdio_oe}, 64'd0);
    rd(12'h24C, v); chk(v == 0, "R1 status after reset", 64'(v), 64'd0);
    rd(12'h23C, v); chk(v == 0, "R1 param after reset", 64'(v), 64'd0);

    // R2 readback and routing
    wr(12'h23C, 32'hFE00_0000 | (32'd1 << 25) | (32'd5 << 22) | 32'h1234);
    rd(12'h23C, v);
    chk(v == 32'h0340_1234, "R2 param readback", 64'(v), 64'h0340_1234);
    chk(bus_internal == 1 && bus_index == 3'd5, "R2 bus routing", {bus_internal, bus_index}, {1'b1, 3'd5});
    wr(12'h000, 32'h0001_0003);
    rd(12'h000, v); chk(v == 32'h0001_0003, "R2 ext rate readback", 64'(v), 64'h0001_0003);
    wr(12'h008, 32'h1000_0000);
    chk(ext_mstr_block == 1, "R2 external master block", 64'(ext_mstr_block), 64'd1);
    wr(12'h004, 32'h0000_0005);

    // external bus, period 3*2=6: Clause 22 write
    do_xact(0, 0, 0, 3'd2, 5'h11, 21'h0000A, 16'hBEEF, 16'h0, 6, "R4 c22 write");
    // internal bus, period 5: Clause 22 read
    do_xact(0, 1, 1, 3'd7, 5'h03, 21'h0001F, 16'h0, 16'hA5C3, 5, "R5 c22 read");

    // R8: start while done is still set does nothing
    r0 = rises;
    wr(12'h248, 32'd2);
    repeat (40) @(negedge clk);
    chk(rises == r0, "R8 no MDC edge while done", 64'(rises), 64'(r0));
    rd(12'h24C, v); chk(v == 1, "R8 done kept", 64'(v), 64'd1);
    wr(12'h248, 32'd0);
    rd(12'h24C, v); chk(v == 0, "R7 zero command clears done", 64'(v), 64'd0);

    // Clause 45 accesses
    do_xact(1, 0, 0, 3'd1, 5'h07, {5'h1E, 16'h8001}, 16'h55AA, 16'h0, 6, "R6 c45 write");
    do_xact(1, 1, 1, 3'd0, 5'h1C, {5'h01, 16'h0F0F}, 16'h0, 16'h3C5A, 5, "R6 c45 read");

    // R3 divisor zero counts as one: dividend 1 -> period 2
    wr(12'h004, 32'h0001_0000);
    do_xact(0, 1, 1, 3'd4, 5'h09, 21'h00015, 16'h0, 16'hF00D, 2, "R3 div0 read");

    // R7 abort mid-frame
    mon_en = 0;
    wr(12'h248, 32'd0);
    wr(12'h23C, 32'h0000_ABCD);
    wr(12'h248, 32'd1);
    repeat (100) @(negedge clk);
    wr(12'h248, 32'd0);
    chk(mdc == 0 && mdio_oe == 0, "R7 abort idles lines", {mdc, mdio_oe}, 64'd0);
    rd(12'h24C, v); chk(v == 0, "R7 abort leaves done clear", 64'(v), 64'd0);
    r0 = rises;
    repeat (40) @(negedge clk);
    chk(rises == r0, "R7 no MDC after abort", 64'(rises), 64'(r0));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule